// File: doc/BRIEF.md
# Presettable Counter with Cascade Enables

A synchronous up-counter, four bits wide by default, that wraps from its all-ones state back to zero. It can be preset from a parallel data bus. Two count enables take part in counting, and the counter advances only when both are high. The two enables have different jobs in a chain of stages. The enable shared by all stages starts and stops the whole chain. The chained enable also qualifies the terminal-count output, so each stage's terminal count can drive the chained enable of the next, more significant stage. The result is a wider counter in which every bit changes on the same clock edge.

A build-time parameter picks the clear style. With `ASYNC_CLEAR = 1`, pulling the active-low clear low zeroes the state at once, without waiting for a clock edge. With `ASYNC_CLEAR = 0`, the clear is sampled like any other control and zeroes the state on the next rising edge. In both styles the clear takes priority over preset and count, preset takes priority over count, and hold applies when nothing else does.

Top module: `preset_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, rst_ni low forces q_o to 0 immediately, without a clock edge, and keeps it at 0 while low, whatever the other inputs are.
- R2: With ASYNC_CLEAR=0, rst_ni low leaves q_o unchanged until the next rising edge of clk_i, where q_o becomes 0 regardless of load_ni, cnt_en_i and chain_en_i.
- R3: With rst_ni high and load_ni low, the next rising edge copies data_i into q_o, whatever cnt_en_i and chain_en_i are.
- R4: With rst_ni and load_ni high and both cnt_en_i and chain_en_i high, each rising edge adds one to q_o modulo 2^WIDTH, so 15 is followed by 0.
- R5: With rst_ni and load_ni high and either cnt_en_i or chain_en_i low, q_o holds its value across rising edges.
- R6: carry_o is 1 exactly when chain_en_i is 1 and q_o is all ones (15). It follows chain_en_i combinationally, within the same cycle.
- R7: Two instances, with the upper chain_en_i driven by the lower carry_o and cnt_en_i shared, count as one 8-bit counter (lower instance = bits 3:0). This includes the carry from 0x0F to 0x10 and the wrap from 0xFF to 0x00, where the upper carry_o is 1 at 0xFF.
- R8: Precedence is clear, then load, then count, then hold. Load with both enables high loads data_i rather than counting. Clear with load low gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low clear, asynchronous or synchronous by ASYNC_CLEAR |
| load_ni | input | 1 | Active-low parallel preset enable |
| cnt_en_i | input | 1 | Count enable shared by all stages of a chain |
| chain_en_i | input | 1 | Count enable that also gates carry_o |
| data_i | input | WIDTH | Parallel preset value |
| q_o | output | WIDTH | Counter state |
| carry_o | output | 1 | Terminal count: chain_en_i and state all ones |

## Verification
Clear and preset can fall in the same cycle as counting, and the bench provokes this in two ways. It pulls load low while both enables are high. It also drops the clear half-way through a clock period while load is low and counting is enabled. An asynchronous and a synchronous instance share these inputs. The asynchronous one must read zero before the next edge, and the synchronous one must keep its old value until that edge. Preset with counting enabled must land on the data value, not on that value plus one. Each step is compared against a model that applies the stated precedence.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
  import pcnt_pkg::*;
#(
  parameter int ASYNC_CLEAR = 1
) (
  input  logic  rst_ni,
  input  logic  load_ni,
  input  logic  cnt_en_i,
  input  logic  chain_en_i,
  output mode_e mode_o
);
  localparam bit SyncClr = (ASYNC_CLEAR == 0);

  // fixed priority: clear > load > count > hold
  always_comb begin
    if (SyncClr && !rst_ni)        mode_o = MODE_CLEAR;
    else if (!load_ni)             mode_o = MODE_LOAD;
    else if (cnt_en_i && chain_en_i) mode_o = MODE_COUNT;
    else                           mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/pcnt_state_reg.sv
module pcnt_state_reg
  import pcnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int ASYNC_CLEAR = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_nx;

  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: q_nx = '0;
      MODE_LOAD:  q_nx = data_i;
      MODE_COUNT: q_nx = q_q + 1'b1;
      default:    q_nx = q_q;
    endcase
  end

  generate
    if (ASYNC_CLEAR != 0) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_nx;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) q_q <= q_nx;
    end
  endgenerate

  assign q_o = q_q;

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD) |=> (q_o == $past(data_i)));
endmodule

// File: rtl/pcnt_tc.sv
module pcnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             chain_en_i,
  output logic             tc_o
);
  assign tc_o = chain_en_i & (&q_i);
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import pcnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int ASYNC_CLEAR = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             cnt_en_i,
  input  logic             chain_en_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] QMax = '1;

  mode_e mode;

  pcnt_mode_dec #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_dec (
    .rst_ni     (rst_ni),
    .load_ni    (load_ni),
    .cnt_en_i   (cnt_en_i),
    .chain_en_i (chain_en_i),
    .mode_o     (mode)
  );

  pcnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .data_i (data_i),
    .q_o    (q_o)
  );

  pcnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i        (q_o),
    .chain_en_i (chain_en_i),
    .tc_o       (carry_o)
  );

  p_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && chain_en_i) |=> (q_o == WIDTH'($past(q_o) + 1'b1)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_en_i && chain_en_i)) |=> $stable(q_o));

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && cnt_en_i && load_ni) |=> (q_o == '0));

  p_carry_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (chain_en_i && q_o == QMax));

  p_prec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && cnt_en_i && chain_en_i) |=> (q_o == $past(data_i)));

  generate
    if (ASYNC_CLEAR != 0) begin : g_chk_async
      p_async_clr_r1: assert property (@(posedge clk_i)
        !rst_ni |-> (q_o == '0));
    end else begin : g_chk_sync
      p_sync_clr_r2: assert property (@(posedge clk_i)
        !rst_ni |=> (q_o == '0));
    end
  endgenerate
endmodule

// File: tb/sim_preset_counter.sv
module sim_preset_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] data = '0;
  logic [3:0] q_a, q_s;
  logic       carry_a, carry_s;

  logic       c_rst_n = 1'b1, c_load_n = 1'b1, c_cnt_en = 1'b0;
  logic [7:0] c_data = '0;
  logic [3:0] c_lo, c_hi;
  logic       c_tc_lo, c_tc_hi;

  logic [3:0] exp_a = '0, exp_s = '0;
  logic [7:0] exp_c = '0;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .cnt_en_i(cnt_en),
    .chain_en_i(chain_en), .data_i(data), .q_o(q_a), .carry_o(carry_a));

  preset_counter #(.WIDTH(4), .ASYNC_CLEAR(0)) u_sync (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .cnt_en_i(cnt_en),
    .chain_en_i(chain_en), .data_i(data), .q_o(q_s), .carry_o(carry_s));

  preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1)) u_lo (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(c_load_n), .cnt_en_i(c_cnt_en),
    .chain_en_i(1'b1), .data_i(c_data[3:0]), .q_o(c_lo), .carry_o(c_tc_lo));

  preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1)) u_hi (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(c_load_n), .cnt_en_i(c_cnt_en),
    .chain_en_i(c_tc_lo), .data_i(c_data[7:4]), .q_o(c_hi), .carry_o(c_tc_hi));

  function automatic logic [3:0] nxt(logic [3:0] q, logic r, logic ld,
                                     logic ce, logic ch, logic [3:0] d);
    if (!r)            return 4'd0;
    else if (!ld)      return d;
    else if (ce && ch) return q + 4'd1;
    else               return q;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " async q"}, {4'd0, q_a}, {4'd0, exp_a});
    chk({req, " sync q"},  {4'd0, q_s}, {4'd0, exp_s});
    chk({req, " carry"},   {7'd0, carry_a}, {7'd0, (chain_en && exp_a == 4'hF)});
  endtask

  // model advances with the inputs held before the edge; sample at negedge
  task automatic tick();
    exp_a = nxt(exp_a, rst_n, load_n, cnt_en, chain_en, data);
    exp_s = nxt(exp_s, rst_n, load_n, cnt_en, chain_en, data);
    if (!c_rst_n)       exp_c = 8'd0;
    else if (!c_load_n) exp_c = c_data;
    else if (c_cnt_en)  exp_c = exp_c + 8'd1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; c_rst_n = 1'b0;
    tick(); tick();
    chk_all("R1/R2 reset");
    chk("R7 cascade reset", {c_hi, c_lo}, 8'h00);
    rst_n = 1'b1; c_rst_n = 1'b1;
    tick();
  endtask

  task automatic t_load();
    data = 4'hA; load_n = 1'b0; cnt_en = 1'b0; chain_en = 1'b0;
    tick(); chk_all("R3 load enables low");
    data = 4'h5; cnt_en = 1'b1; chain_en = 1'b0;
    tick(); chk_all("R3 load cnt_en only");
    load_n = 1'b1; cnt_en = 1'b0;
  endtask

  task automatic t_count_wrap();
    data = 4'hD; load_n = 1'b0;
    tick(); load_n = 1'b1;
    cnt_en = 1'b1; chain_en = 1'b1;
    #1 chk_all("R6 carry low at 13");
    for (int i = 0; i < 5; i++) begin
      tick(); chk_all("R4 count/wrap");
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_carry_comb();
    data = 4'hF; load_n = 1'b0; tick(); load_n = 1'b1;
    chain_en = 1'b1; #1;
    chk("R6 carry with chain high", {7'd0, carry_a}, 8'd1);
    chain_en = 1'b0; #1;
    chk("R6 carry follows chain low", {7'd0, carry_a}, 8'd0);
    chain_en = 1'b1; #1;
    chk("R6 carry follows chain high", {7'd0, carry_a}, 8'd1);
    chk("R6 carry sync variant", {7'd0, carry_s}, 8'd1);
    chain_en = 1'b0;
  endtask

  task automatic t_hold();
    data = 4'h6; load_n = 1'b0; tick(); load_n = 1'b1;
    cnt_en = 1'b1; chain_en = 1'b0;
    tick(); tick(); chk_all("R5 hold chain low");
    cnt_en = 1'b0; chain_en = 1'b1;
    tick(); tick(); chk_all("R5 hold cnt low");
    chk("R5 value kept", {4'd0, q_a}, 8'h06);
    chain_en = 1'b0;
  endtask

  task automatic t_load_vs_count();
    data = 4'h3; load_n = 1'b0; cnt_en = 1'b1; chain_en = 1'b1;
    tick(); chk_all("R8 load over count");
    chk("R8 load not plus one", {4'd0, q_a}, 8'h03);
    load_n = 1'b1;
    tick(); chk_all("R8 count after load");
  endtask

  task automatic t_mid_clear();
    load_n = 1'b0; data = 4'h9; cnt_en = 1'b1; chain_en = 1'b1;
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    exp_a = 4'd0;
    chk("R1 async clear mid cycle", {4'd0, q_a}, 8'h00);
    chk("R2 sync waits for edge", {4'd0, q_s}, {4'd0, exp_s});
    tick(); chk_all("R8 clear over load");
    tick(); chk_all("R1/R2 clear held");
    rst_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    tick(); chk_all("R2 release");
  endtask

  task automatic t_cascade();
    c_data = 8'h0C; c_load_n = 1'b0; tick(); c_load_n = 1'b1;
    c_cnt_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(); chk("R7 cascade 0x0F->0x10", {c_hi, c_lo}, exp_c);
    end
    c_cnt_en = 1'b0; c_data = 8'hFE; c_load_n = 1'b0; tick(); c_load_n = 1'b1;
    c_cnt_en = 1'b1;
    tick(); chk("R7 cascade at 0xFF", {c_hi, c_lo}, 8'hFF);
    chk("R7 upper carry at 0xFF", {7'd0, c_tc_hi}, 8'd1);
    tick(); chk("R7 cascade wrap", {c_hi, c_lo}, 8'h00);
    c_cnt_en = 1'b0;
    tick(); chk("R7 cascade hold", {c_hi, c_lo}, exp_c);
  endtask

  initial begin
    #1 rst_n = 1'b0; c_rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_count_wrap();
    t_carry_comb();
    t_hold();
    t_load_vs_count();
    t_mid_clear();
    t_cascade();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule